// File: doc/BRIEF.md
# ALU Operand Bypass Unit

This block sits in front of the ALU of a five-stage pipeline and decides, every cycle, where the two ALU operands come from. The instruction in stage 3 carries its operands in two latches, X (from the first source field) and Y (from the second source field or an immediate). Results that are still travelling down the pipeline are held in the stage-4 result register Z4 and the stage-5 result register Z5. The unit compares the destination register of the instructions in stages 4 and 5 against the source fields of the instruction in stage 3 and, on a match, hands the ALU the in-flight result instead of the stale latch value.

Only results that are already computed can be bypassed. An ALU result exists in Z4 one stage after execution, so ALU-to-ALU dependences never wait. A load's data only exists once it reaches stage 5, so a load in stage 4 whose destination feeds stage 3 makes the unit raise a one-cycle stall; on the next cycle the load sits in stage 5 and Z5 (which then holds the memory data) is bypassed. When both later stages match the same source, stage 4 wins because it holds the more recent write. The Y operand is only bypassed for register-register forms; immediate forms keep their latched Y.

The datapath is purely combinational; the clock and reset only qualify the embedded checks. Every stage carries a 2-bit class code alongside its register fields so the comparisons can be made without re-decoding opcodes.

Top module: `alu_bypass_unit`

## Requirements
- R1: When stage 3 and stage 4 both have class ALU (code 1) and the stage-4 destination equals the stage-3 first source, `opa_out` equals `z4`.
- R2: When stage 3 has class ALU, stage 5 has class ALU (1) or LOAD (2), its destination equals the stage-3 first source, and R1 does not apply, `opa_out` equals `z5`.
- R3: When stage 3 and stage 4 both have class ALU, `s3_imm` is 0 and the stage-4 destination equals the stage-3 second source, `opb_out` equals `z4`.
- R4: When stage 3 has class ALU, `s3_imm` is 0, stage 5 has class ALU or LOAD, its destination equals the stage-3 second source and R3 does not apply, `opb_out` equals `z5`.
- R5: When `s3_imm` is 1, `opb_out` equals `y3` whatever the later stages hold.
- R6: When stage 4 and stage 5 both match the same source of an ALU stage 3 and stage 4 is ALU, the stage-4 value `z4` is selected.
- R7: When stage 3 is not class ALU (codes 0 NONE, 2 LOAD, 3 OTHER), or no later stage matches, the outputs equal `x3` and `y3` and `stall` is 0; a stage whose class is NONE or OTHER never supplies a value.
- R8: `stall` is 1 exactly when stage 3 is class ALU, stage 4 is class LOAD, and the stage-4 destination equals the first source or (with `s3_imm` 0) the second source; a stage-4 load never supplies `z4`.
- R9: An ALU instruction in stage 4 or stage 5 never causes `stall`, whatever its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, qualifies the embedded checks only |
| rst_n | input | 1 | Active-low reset, disables the checks |
| s3_cls | input | 2 | Stage-3 class: 0 NONE, 1 ALU, 2 LOAD, 3 OTHER |
| s3_imm | input | 1 | Stage-3 second operand is an immediate |
| s3_src1 | input | REG_W | Stage-3 first source register |
| s3_src2 | input | REG_W | Stage-3 second source register |
| x3 | input | DATA_W | Latched first operand |
| y3 | input | DATA_W | Latched second operand |
| s4_cls | input | 2 | Stage-4 class |
| s4_dst | input | REG_W | Stage-4 destination register |
| z4 | input | DATA_W | Stage-4 result register |
| s5_cls | input | 2 | Stage-5 class |
| s5_dst | input | REG_W | Stage-5 destination register |
| z5 | input | DATA_W | Stage-5 result register (ALU result or load data) |
| opa_out | output | DATA_W | First ALU operand after bypass |
| opb_out | output | DATA_W | Second ALU operand after bypass |
| stall | output | 1 | Load-use stall request |

## Verification
The checks assume the surrounding pipeline holds the stage inputs stable for a whole cycle and that `z5` already contains the memory data whenever stage 5 is a load. The operand values are not constrained while `stall` is high, since the pipeline discards that cycle, so the bench compares only the stall flag on such vectors. Stimulus changes on the falling edge and uses distinct data words in `x3`, `y3`, `z4` and `z5` so each selection is identifiable; it walks class combinations, matching and non-matching register fields, and the immediate flag.

// File: rtl/alu_bypass_pkg.sv
package alu_bypass_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_OTHER = 2'd3
    } stage_cls_e;

    typedef enum logic [1:0] {
        PICK_LATCH = 2'd0,
        PICK_NEAR  = 2'd1,
        PICK_FAR   = 2'd2
    } pick_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/bypass_compare.sv
module bypass_compare
    import alu_bypass_pkg::*;
#(
    parameter int unsigned REG_W      = 5,
    parameter bit          LOAD_READY = 1'b0
) (
    input  stage_cls_e         prod_cls,
    input  logic [REG_W-1:0]   prod_dst,
    input  logic [REG_W-1:0]   cons_src,
    input  logic               cons_used,
    output logic               hit,
    output logic               not_ready
);

    logic fields_eq;
    logic delivers;

    always_comb begin
        fields_eq = cons_used && (prod_dst == cons_src);
        if (LOAD_READY) begin
            delivers = (prod_cls == CLS_ALU) || (prod_cls == CLS_LOAD);
        end else begin
            delivers = (prod_cls == CLS_ALU);
        end
        hit       = fields_eq && delivers;
        not_ready = fields_eq && !LOAD_READY && (prod_cls == CLS_LOAD);
    end

endmodule

// File: rtl/bypass_operand.sv
module bypass_operand
    import alu_bypass_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               use_src,
    input  logic [REG_W-1:0]   src,
    input  logic [DATA_W-1:0]  latched,
    input  stage_cls_e         near_cls,
    input  logic [REG_W-1:0]   near_dst,
    input  logic [DATA_W-1:0]  near_val,
    input  stage_cls_e         far_cls,
    input  logic [REG_W-1:0]   far_dst,
    input  logic [DATA_W-1:0]  far_val,
    output logic [DATA_W-1:0]  value,
    output logic               pending
);

    typedef struct packed {
        pick_e              pick;
        logic [DATA_W-1:0]  val;
        logic               wait_load;
    } sel_t;

    logic near_hit;
    logic near_wait;
    logic far_hit;
    logic far_wait;
    sel_t sel_d;

    bypass_compare #(
        .REG_W      (REG_W),
        .LOAD_READY (1'b0)
    ) u_near (
        .prod_cls  (near_cls),
        .prod_dst  (near_dst),
        .cons_src  (src),
        .cons_used (use_src),
        .hit       (near_hit),
        .not_ready (near_wait)
    );

    bypass_compare #(
        .REG_W      (REG_W),
        .LOAD_READY (1'b1)
    ) u_far (
        .prod_cls  (far_cls),
        .prod_dst  (far_dst),
        .cons_src  (src),
        .cons_used (use_src),
        .hit       (far_hit),
        .not_ready (far_wait)
    );

    always_comb begin
        sel_d = '{pick: PICK_LATCH, val: latched, wait_load: 1'b0};
        if (near_hit) begin
            sel_d.pick = PICK_NEAR;
            sel_d.val  = near_val;
        end else if (far_hit) begin
            sel_d.pick = PICK_FAR;
            sel_d.val  = far_val;
        end
        sel_d.wait_load = near_wait;
    end

    assign value   = sel_d.val;
    assign pending = sel_d.wait_load;

    AST_FAR_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        !far_wait);                                                   // R2
    AST_NEAR_LOAD_NOT_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
        (near_cls == CLS_LOAD) |-> (sel_d.pick != PICK_NEAR));        // R8
    AST_NEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (near_hit && far_hit) |-> (value == near_val));               // R6
    AST_UNUSED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        !use_src |-> (value == latched && !pending));                 // R7

endmodule

// File: rtl/alu_bypass_unit.sv
module alu_bypass_unit
    import alu_bypass_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         s3_cls,
    input  logic               s3_imm,
    input  logic [REG_W-1:0]   s3_src1,
    input  logic [REG_W-1:0]   s3_src2,
    input  logic [DATA_W-1:0]  x3,
    input  logic [DATA_W-1:0]  y3,
    input  logic [1:0]         s4_cls,
    input  logic [REG_W-1:0]   s4_dst,
    input  logic [DATA_W-1:0]  z4,
    input  logic [1:0]         s5_cls,
    input  logic [REG_W-1:0]   s5_dst,
    input  logic [DATA_W-1:0]  z5,
    output logic [DATA_W-1:0]  opa_out,
    output logic [DATA_W-1:0]  opb_out,
    output logic               stall
);

    localparam int unsigned NOPS = NUM_OPERANDS;

    stage_cls_e         cls3;
    stage_cls_e         cls4;
    stage_cls_e         cls5;
    logic               cons_alu;
    logic [REG_W-1:0]   src_f   [NOPS];
    logic [DATA_W-1:0]  latch_f [NOPS];
    logic [DATA_W-1:0]  val_f   [NOPS];
    logic               use_f   [NOPS];
    logic [NOPS-1:0]    wait_f;

    always_comb begin
        cls3       = stage_cls_e'(s3_cls);
        cls4       = stage_cls_e'(s4_cls);
        cls5       = stage_cls_e'(s5_cls);
        cons_alu   = (cls3 == CLS_ALU);
        src_f[0]   = s3_src1;
        src_f[1]   = s3_src2;
        latch_f[0] = x3;
        latch_f[1] = y3;
        use_f[0]   = cons_alu;
        use_f[1]   = cons_alu && !s3_imm;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        bypass_operand #(
            .DATA_W (DATA_W),
            .REG_W  (REG_W)
        ) u_opnd (
            .clk      (clk),
            .rst_n    (rst_n),
            .use_src  (use_f[g]),
            .src      (src_f[g]),
            .latched  (latch_f[g]),
            .near_cls (cls4),
            .near_dst (s4_dst),
            .near_val (z4),
            .far_cls  (cls5),
            .far_dst  (s5_dst),
            .far_val  (z5),
            .value    (val_f[g]),
            .pending  (wait_f[g])
        );
    end

    assign opa_out = val_f[0];
    assign opb_out = val_f[1];
    assign stall   = |wait_f;

    AST_A_FROM_Z4: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_cls == 2'd1 && s4_cls == 2'd1 && s4_dst == s3_src1) |-> (opa_out == z4));   // R1
    AST_B_FROM_Z4: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_cls == 2'd1 && !s3_imm && s4_cls == 2'd1 && s4_dst == s3_src2)
        |-> (opb_out == z4));                                                           // R3
    AST_IMM_KEEPS_Y: assert property (@(posedge clk) disable iff (!rst_n)
        s3_imm |-> (opb_out == y3));                                                    // R5
    AST_NON_ALU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_cls != 2'd1) |-> (opa_out == x3 && opb_out == y3 && !stall));               // R7
    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (s4_cls == 2'd2 && s3_cls == 2'd1));                                  // R8
    AST_ALU_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s4_cls == 2'd1) |-> !stall);                                                   // R9

endmodule

// File: tb/alu_bypass_unit_tb.sv
module alu_bypass_unit_tb;

    localparam int DW = 32;
    localparam int RW = 5;

    typedef struct {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          stl;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    s3_cls = '0, s4_cls = '0, s5_cls = '0;
    logic          s3_imm = 1'b0;
    logic [RW-1:0] s3_src1 = '0, s3_src2 = '0, s4_dst = '0, s5_dst = '0;
    logic [DW-1:0] x3 = 32'h1111_0000, y3 = 32'h2222_0000;
    logic [DW-1:0] z4 = 32'h4444_0000, z5 = 32'h5555_0000;
    logic [DW-1:0] opa_out, opb_out;
    logic          stall;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   drv_done = 1'b0;

    always #4 clk = ~clk;

    alu_bypass_unit #(.DATA_W(DW), .REG_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s3_cls(s3_cls), .s3_imm(s3_imm), .s3_src1(s3_src1), .s3_src2(s3_src2),
        .x3(x3), .y3(y3),
        .s4_cls(s4_cls), .s4_dst(s4_dst), .z4(z4),
        .s5_cls(s5_cls), .s5_dst(s5_dst), .z5(z5),
        .opa_out(opa_out), .opb_out(opb_out), .stall(stall)
    );

    task automatic drive(input string tag, input logic [1:0] c3, input logic imm,
                         input logic [RW-1:0] r1, input logic [RW-1:0] r2,
                         input logic [1:0] c4, input logic [RW-1:0] d4,
                         input logic [1:0] c5, input logic [RW-1:0] d5);
        exp_t e;
        logic alu3;
        @(negedge clk);
        s3_cls = c3; s3_imm = imm; s3_src1 = r1; s3_src2 = r2;
        s4_cls = c4; s4_dst = d4; s5_cls = c5; s5_dst = d5;
        x3 = x3 + 1; y3 = y3 + 1; z4 = z4 + 1; z5 = z5 + 1;
        alu3 = (c3 == 2'd1);
        e.tag = tag;
        if (alu3 && c4 == 2'd1 && d4 == r1)                            e.a = z4;
        else if (alu3 && (c5 == 2'd1 || c5 == 2'd2) && d5 == r1)       e.a = z5;
        else                                                           e.a = x3;
        if (alu3 && !imm && c4 == 2'd1 && d4 == r2)                    e.b = z4;
        else if (alu3 && !imm && (c5 == 2'd1 || c5 == 2'd2) && d5 == r2) e.b = z5;
        else                                                           e.b = y3;
        e.stl = alu3 && c4 == 2'd2 && (d4 == r1 || (!imm && d4 == r2));
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (stall !== e.stl) begin
                    n_bad++;
                    $display("FAIL %s stall: actual %0b expected %0b", e.tag, stall, e.stl);
                end else if (!e.stl && (opa_out !== e.a || opb_out !== e.b)) begin
                    n_bad++;
                    $display("FAIL %s operands: actual %h/%h expected %h/%h",
                             e.tag, opa_out, opb_out, e.a, e.b);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!drv_done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        // reset state: idle pipeline, latches pass through
        drive("R7_reset", 2'd0, 1'b0, 5'd1, 5'd2, 2'd0, 5'd1, 2'd0, 5'd2);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive("R1_z4_to_a",      2'd1, 1'b0, 5'd3, 5'd4, 2'd1, 5'd3, 2'd0, 5'd0);
        drive("R2_z5_alu_to_a",  2'd1, 1'b0, 5'd3, 5'd4, 2'd1, 5'd9, 2'd1, 5'd3);
        drive("R2_z5_load_to_a", 2'd1, 1'b0, 5'd6, 5'd4, 2'd0, 5'd6, 2'd2, 5'd6);
        drive("R3_z4_to_b",      2'd1, 1'b0, 5'd3, 5'd4, 2'd1, 5'd4, 2'd0, 5'd4);
        drive("R4_z5_to_b",      2'd1, 1'b0, 5'd3, 5'd7, 2'd3, 5'd7, 2'd2, 5'd7);
        drive("R5_imm_no_b_z4",  2'd1, 1'b1, 5'd3, 5'd4, 2'd1, 5'd4, 2'd0, 5'd0);
        drive("R5_imm_no_b_z5",  2'd1, 1'b1, 5'd3, 5'd8, 2'd0, 5'd0, 2'd1, 5'd8);
        drive("R6_prio_a",       2'd1, 1'b0, 5'd5, 5'd4, 2'd1, 5'd5, 2'd1, 5'd5);
        drive("R6_prio_both",    2'd1, 1'b0, 5'd5, 5'd5, 2'd1, 5'd5, 2'd2, 5'd5);
        drive("R6_split",        2'd1, 1'b0, 5'd5, 5'd6, 2'd1, 5'd6, 2'd1, 5'd5);
        drive("R7_s3_load",      2'd2, 1'b0, 5'd3, 5'd4, 2'd1, 5'd3, 2'd1, 5'd4);
        drive("R7_s3_other",     2'd3, 1'b0, 5'd3, 5'd4, 2'd2, 5'd3, 2'd2, 5'd4);
        drive("R7_prod_other",   2'd1, 1'b0, 5'd3, 5'd4, 2'd3, 5'd3, 2'd3, 5'd4);
        drive("R7_prod_none",    2'd1, 1'b0, 5'd3, 5'd4, 2'd0, 5'd3, 2'd0, 5'd4);
        drive("R7_no_match",     2'd1, 1'b0, 5'd3, 5'd4, 2'd1, 5'd9, 2'd2, 5'd10);
        drive("R8_load_a",       2'd1, 1'b0, 5'd3, 5'd4, 2'd2, 5'd3, 2'd0, 5'd0);
        drive("R8_load_b",       2'd1, 1'b0, 5'd3, 5'd4, 2'd2, 5'd4, 2'd1, 5'd4);
        drive("R8_load_imm_b",   2'd1, 1'b1, 5'd3, 5'd4, 2'd2, 5'd4, 2'd0, 5'd0);
        drive("R8_load_miss",    2'd1, 1'b0, 5'd3, 5'd4, 2'd2, 5'd11, 2'd1, 5'd3);
        drive("R8_then_z5",      2'd1, 1'b0, 5'd3, 5'd4, 2'd0, 5'd0, 2'd2, 5'd3);
        drive("R9_alu4_match",   2'd1, 1'b0, 5'd12, 5'd12, 2'd1, 5'd12, 2'd0, 5'd0);
        drive("R9_alu5_match",   2'd1, 1'b0, 5'd12, 5'd13, 2'd3, 5'd0, 2'd1, 5'd13);
        for (int i = 0; i < 32; i++) begin
            drive("R1_R3_sweep", 2'd1, 1'(i[0]), 5'(i), 5'(31 - i), 2'd1, 5'(i), 2'd2, 5'(31 - i));
        end
        repeat (3) @(posedge clk);
        drv_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule